// File: doc/BRIEF.md
# Banked Block-Memory Matrix

This block builds one large synchronous single-port memory out of a grid of identical RAM banks. The grid has five columns and four rows. The columns sit side by side and widen the stored word. The rows are stacked and deepen the address space. Each bank holds 1024 locations of 18 bits: 16 data bits and 2 parity bits. The parity bits are always stored as zero.

A single request port carries an address, an 80-bit write word, a write request and a read request. The top two address bits choose a row, and every bank in that row is driven in the same cycle. A read therefore returns the whole 90-bit row word in a single access, instead of five separate accesses.

When both requests are asserted in the same cycle, the read wins. The output is registered. It changes only on a read and keeps its last value through writes and idle cycles. The bank contents are inferred arrays. Reset clears the output path but leaves the stored contents alone.

Top module: `bmx_matrix`

## Requirements
- R1: While reset is high on a clock edge, the output register and the registered row select are cleared, so `rdata` reads all zeros after reset until the first read.
- R2: A write stores `wdata[16*c +: 16]` into column c at the address given. A later read of that address returns that value in `rdata[18*c +: 16]`.
- R3: A read has a latency of one cycle. `rdata` takes the new word at the first rising edge at which `rd_req` is sampled high, and not before.
- R4: When `rd_req` and `wr_req` are both high, the cycle is a read. The write data is discarded and the addressed location keeps its old contents.
- R5: During a write cycle (`wr_req` high, `rd_req` low), `rdata` keeps the value it last returned.
- R6: In a cycle with neither request asserted, `rdata` does not change and no location is modified.
- R7: Address bits [11:10] select the row and bits [9:0] select the location inside each bank. A write to one row leaves the same offset in every other row unchanged.
- R8: All five columns of the selected row are returned together in one read, with column c in `rdata[18*c +: 18]`.
- R9: The two parity bits of each column slice, `rdata[18*c+16 +: 2]`, always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Active-high synchronous reset of the output path |
| addr | input | 12 | Row select in [11:10], bank offset in [9:0] |
| wdata | input | 80 | Write word, 16 bits per column |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request; takes priority over `wr_req` |
| rdata | output | 90 | Registered row word, 18 bits per column |

## Verification
The bench fills every one of the 4096 addresses with a pattern that depends on both the address and the column, then reads all of them back. A decoder that used the wrong row bits, or that let a write reach other rows, would return another row's pattern. Swapped column wiring would show the wrong per-column value, and nonzero parity bits would fail the zero check.

Separate directed cases cover the remaining corners:
- Both requests high at once: a design that let the write through would change the stored word.
- A write, or an idle cycle, after a read: a design that refreshed the output on every enabled cycle would lose the last read value.
- A probe just before the read edge: a read that came out with zero latency would be caught there.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int BMX_COLS   = 5;
  localparam int BMX_ROWS   = 4;
  localparam int BMX_OFF_W  = 10;
  localparam int BMX_DATA_W = 16;
  localparam int BMX_PAR_W  = 2;

  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_READ  = 2'd1,
    REQ_WRITE = 2'd2
  } bmx_req_e;

  // Read wins over write; neither means idle.
  function automatic bmx_req_e classify(input logic rd, input logic wr);
    if (rd)      return REQ_READ;
    else if (wr) return REQ_WRITE;
    else         return REQ_IDLE;
  endfunction
endpackage

// File: rtl/bmx_bank.sv
module bmx_bank #(
  parameter int AW = 10,
  parameter int W  = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [0:DEPTH-1];
  logic         do_write;
  logic         do_read;

  assign do_write = en && we;
  assign do_read  = en && !we;

  always_ff @(posedge clk) begin
    if (do_write) mem[addr] <= din;
  end

  // Output changes on a read only; it holds through writes and idle cycles.
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (do_read) dout <= mem[addr];
  end

  // R5
  hold_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    do_write |=> $stable(dout));

  // R6
  idle_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout));
endmodule

// File: rtl/bmx_row_decode.sv
module bmx_row_decode
  import bmx_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic             wr_req,
  input  logic [ROW_W-1:0] row,
  output logic [ROWS-1:0]  row_en,
  output logic [ROWS-1:0]  row_we,
  output logic             rd_fire
);
  bmx_req_e kind;

  assign kind    = classify(rd_req, wr_req);
  assign rd_fire = (kind == REQ_READ);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit       = (row == ROW_W'(r));
    assign row_en[r] = hit && (kind != REQ_IDLE);
    assign row_we[r] = hit && (kind == REQ_WRITE);
  end

  // R7
  one_row_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_en));

  // R4
  rd_wins_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (row_we == '0));

  // R6
  idle_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !wr_req) |-> (row_en == '0));
endmodule

// File: rtl/bmx_row_mux.sv
module bmx_row_mux #(
  parameter int ROWS  = 4,
  parameter int ROW_W = 2,
  parameter int RW    = 90
) (
  input  logic [ROWS-1:0][RW-1:0] row_words,
  input  logic [ROW_W-1:0]        sel,
  output logic [RW-1:0]           word
);
  always_comb begin
    word = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (sel == ROW_W'(r)) word = row_words[r];
    end
  end
endmodule

// File: rtl/bmx_matrix.sv
module bmx_matrix
  import bmx_pkg::*;
#(
  parameter int COLS   = BMX_COLS,
  parameter int ROWS   = BMX_ROWS,
  parameter int OFF_W  = BMX_OFF_W,
  parameter int DATA_W = BMX_DATA_W,
  parameter int PAR_W  = BMX_PAR_W,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int ADDR_W  = ROW_W + OFF_W,
  localparam int CELL_W  = DATA_W + PAR_W,
  localparam int WDATA_W = COLS * DATA_W,
  localparam int RDATA_W = COLS * CELL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WDATA_W-1:0] wdata,
  input  logic               wr_req,
  input  logic               rd_req,
  output logic [RDATA_W-1:0] rdata
);
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: ROW_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  // Stored cell: parity bits above the data bits, always zero.
  function automatic logic [CELL_W-1:0] to_cell(input logic [DATA_W-1:0] d);
    return {{PAR_W{1'b0}}, d};
  endfunction

  logic [ROW_W-1:0]               row_sel;
  logic [OFF_W-1:0]               offset;
  logic [ROWS-1:0]                row_en;
  logic [ROWS-1:0]                row_we;
  logic                           rd_fire;
  logic [ROW_W-1:0]               row_q;
  logic [ROWS-1:0][RDATA_W-1:0]   row_words;

  assign row_sel = row_of(addr);
  assign offset  = off_of(addr);

  bmx_row_decode #(.ROWS(ROWS), .ROW_W(ROW_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .row     (row_sel),
    .row_en  (row_en),
    .row_we  (row_we),
    .rd_fire (rd_fire)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      bmx_bank #(.AW(OFF_W), .W(CELL_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .en   (row_en[r]),
        .we   (row_we[r]),
        .addr (offset),
        .din  (to_cell(wdata[c*DATA_W +: DATA_W])),
        .dout (row_words[r][c*CELL_W +: CELL_W])
      );
    end
  end

  // Row select follows reads only, so the mux stays on the last row read.
  always_ff @(posedge clk) begin
    if (rst)          row_q <= '0;
    else if (rd_fire) row_q <= row_sel;
  end

  bmx_row_mux #(.ROWS(ROWS), .ROW_W(ROW_W), .RW(RDATA_W)) u_mux (
    .row_words (row_words),
    .sel       (row_q),
    .word      (rdata)
  );

  // R3
  row_track_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (row_q == $past(row_sel)));

  // R5
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req) |=> $stable(rdata));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_req && !rd_req) |=> $stable(rdata));

  for (genvar c = 0; c < COLS; c++) begin : g_par
    // R9
    parity_zero_chk: assert property (@(posedge clk) disable iff (rst)
      rdata[c*CELL_W + DATA_W +: PAR_W] == '0);
  end
endmodule

// File: tb/bmx_matrix_bench.sv
module bmx_matrix_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 5;
  localparam int NADDR = 4096;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] addr;
  logic [79:0] wdata;
  logic        wr_req;
  logic        rd_req;
  logic [89:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmx_matrix u_bmx_matrix (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_req(wr_req), .rd_req(rd_req), .rdata(rdata)
  );

  function automatic logic [15:0] pat(input int a, input int c, input logic inv);
    logic [31:0] v;
    v = a * 40503 + c * 7919 + 32'h5A3C;
    return inv ? ~v[15:0] : v[15:0];
  endfunction

  function automatic logic [79:0] wword(input int a, input logic inv);
    logic [79:0] w;
    for (int c = 0; c < COLS; c++) w[c*16 +: 16] = pat(a, c, inv);
    return w;
  endfunction

  function automatic logic [89:0] rword(input int a, input logic inv);
    logic [89:0] w;
    for (int c = 0; c < COLS; c++) w[c*18 +: 18] = {2'b00, pat(a, c, inv)};
    return w;
  endfunction

  task automatic check(input string req, input logic [89:0] exp);
    n_checks++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, rdata, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [79:0] d);
    @(negedge clk);
    addr = 12'(a); wdata = d; wr_req = 1'b1; rd_req = 1'b0;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    addr = 12'(a); rd_req = 1'b1; wr_req = 1'b0;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; addr = '0; wdata = '0; wr_req = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1: output cleared by reset
    check("R1", '0);
    rst = 1'b0;

    // R2 R7: fill every address with an address- and column-dependent pattern
    for (int a = 0; a < NADDR; a++) do_write(a, wword(a, 1'b0));
    // R1: writes never touched the output
    check("R1", '0);

    // R2 R7 R8 R9: read everything back, all five columns at once
    for (int a = 0; a < NADDR; a++) begin
      do_read(a);
      check("R2", rword(a, 1'b0));
    end

    // R3: the output is not updated before the read edge
    do_read(100);
    @(negedge clk);
    addr = 12'd2000; rd_req = 1'b1;
    #1;
    check("R3", rword(100, 1'b0));
    @(negedge clk);
    rd_req = 1'b0;
    check("R3", rword(2000, 1'b0));

    // R4: both requests high -> read of old data, no write
    @(negedge clk);
    addr = 12'd1500; wdata = wword(1500, 1'b1); rd_req = 1'b1; wr_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    check("R4", rword(1500, 1'b0));
    do_read(7);
    do_read(1500);
    check("R4", rword(1500, 1'b0));

    // R5: a write after a read leaves the output alone
    do_read(3000);
    do_write(3001, wword(3001, 1'b1));
    check("R5", rword(3000, 1'b0));
    do_write(1, wword(1, 1'b1));
    check("R5", rword(3000, 1'b0));

    // R6: idle cycles hold the output and leave memory unchanged
    repeat (4) @(negedge clk);
    check("R6", rword(3000, 1'b0));
    do_read(3000);
    check("R6", rword(3000, 1'b0));

    // R7: row 1 offset 5 rewritten, other rows at offset 5 untouched
    do_write(1024 + 5, wword(1024 + 5, 1'b1));
    for (int r = 0; r < 4; r++) begin
      do_read(r * 1024 + 5);
      check("R7", rword(r * 1024 + 5, r == 1));
    end

    // R2: earlier writes visible
    do_read(3001);
    check("R2", rword(3001, 1'b1));
    do_read(1);
    check("R2", rword(1, 1'b1));

    // R1: reset clears output again, contents kept
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", '0);
    do_read(1);
    check("R1", rword(1, 1'b1));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule